// File: doc/BRIEF.md
# Retriggerable ADC Overload Detector

This block watches the stream of stereo samples coming out of an audio ADC. It raises one registered overload flag when either channel gets close to digital full scale. A sample counts as an exceedance when its magnitude is above seven eighths of full scale, which is about 1.16 dB below the largest code. Only samples presented with the sample-valid strobe are examined.

Once raised, the flag stays high for a hold time counted in sample periods, 512 by default. Each new exceedance during the hold restarts the hold at its full length. Downstream logic can therefore treat the flag as a level that lasts at least the hold time after the last clip. The hold counter counts strobes, not clock cycles, so the hold time follows the sample rate.

Top module: `ovl_detector`

## Requirements
- R1: On a cycle with `smp_valid` high, if the left or the right sample has an absolute value greater than 7 × 2^(SAMPLE_W−4) (7340032, or 0x700000, for 24 bits), `ovl_flag` is high from the next clock edge.
- R2: Samples are two's complement. A magnitude exactly equal to the threshold does not set the flag; one code beyond it does. This holds for both polarities, so 0x900000 does not trip and 0x8FFFFF does.
- R3: The most negative code (0x800000) is treated as the largest positive magnitude and sets the flag on either channel.
- R4: An exceedance while the flag is already high reloads the hold to its full length of HOLD_SAMPLES strobes.
- R5: The hold advances only on `smp_valid` strobes. With no strobes, the flag holds its value for any number of clock cycles.
- R6: After the last exceedance, the flag stays high through the next HOLD_SAMPLES−1 non-exceeding strobes. It goes low at the clock edge of the HOLD_SAMPLES-th such strobe.
- R7: Synchronous reset (`rst` high at a clock edge) clears the flag and the hold count, so non-exceeding strobes that follow leave the flag low.
- R8: Sample values presented while `smp_valid` is low have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| smp_left | input | SAMPLE_W | Left channel sample, two's complement |
| smp_right | input | SAMPLE_W | Right channel sample, two's complement |
| ovl_flag | output | 1 | Registered overload flag |

## Verification
A table of single-strobe sample pairs probes the comparison. It uses values just inside and just outside the threshold in both polarities, on each channel alone, with the most negative code and with positive full scale. This separates an off-by-one in the compare, a wrong negation and missing saturation. Directed sequences then count strobes across the hold boundary. The boundary is checked once after a single trip, once after a retrigger halfway through, and once with long gaps between strobes. These sequences tell reload from no reload, and strobe counting from clock counting. Reset in the middle of a hold and large samples with the strobe low show whether stale state or ungated input leaks through.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int DEF_SAMPLE_W = 24;
    localparam int DEF_HOLD     = 512;
    localparam int NUM_CH       = 2;
endpackage

// File: rtl/ovl_mag_cmp.sv
module ovl_mag_cmp #(
    parameter int SAMPLE_W = 24,
    parameter logic [SAMPLE_W-1:0] THRESH = 24'h700000
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                over
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W-1:0] mag;

    always_comb begin
        if (sample == MOST_NEG) begin
            mag = MOST_POS;
        end else if (sample[SAMPLE_W-1]) begin
            mag = ~sample + 1'b1;
        end else begin
            mag = sample;
        end
        over = (mag > THRESH);
    end
endmodule

// File: rtl/ovl_hold_timer.sv
module ovl_hold_timer #(
    parameter int HOLD_SAMPLES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic trig,
    output logic flag
);
    localparam int CW = $clog2(HOLD_SAMPLES + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_SAMPLES);
    localparam logic [CW-1:0] ONE     = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (trig) begin
                st_d.cnt  = HOLD_LD;
                st_d.flag = 1'b1;
            end else if (st_q.cnt != '0) begin
                st_d.cnt  = st_q.cnt - ONE;
                st_d.flag = (st_q.cnt != ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R4: a trigger always restores the full hold
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && trig) |=> (st_q.cnt == HOLD_LD));

    // R5: no strobe, no change in the hold count
    p_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q.cnt));

    // R6: last count consumed without trigger drops the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !trig && st_q.cnt == ONE) |=> !flag);
endmodule

// File: rtl/ovl_detector.sv
module ovl_detector #(
    parameter int SAMPLE_W     = ovl_pkg::DEF_SAMPLE_W,
    parameter int HOLD_SAMPLES = ovl_pkg::DEF_HOLD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                ovl_flag
);
    localparam int NCH = ovl_pkg::NUM_CH;
    localparam logic [SAMPLE_W-1:0] THRESH = SAMPLE_W'(7) << (SAMPLE_W - 4);

    logic [SAMPLE_W-1:0] ch_smp [NCH];
    logic [NCH-1:0]      ch_over;
    logic                any_over;

    assign ch_smp[0] = smp_left;
    assign ch_smp[1] = smp_right;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ovl_mag_cmp #(
            .SAMPLE_W (SAMPLE_W),
            .THRESH   (THRESH)
        ) u_cmp (
            .sample (ch_smp[ch]),
            .over   (ch_over[ch])
        );
    end

    assign any_over = |ch_over;

    ovl_hold_timer #(
        .HOLD_SAMPLES (HOLD_SAMPLES)
    ) u_hold (
        .clk  (clk),
        .rst  (rst),
        .tick (smp_valid),
        .trig (any_over),
        .flag (ovl_flag)
    );

    // R1: a qualifying sample raises the flag at the next edge
    p_set_r1: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && any_over) |=> ovl_flag);

    // R8: without a strobe the flag keeps its value
    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(ovl_flag));
endmodule

// File: tb/ovl_detector_tb.sv
module ovl_detector_tb;
    localparam int W    = 24;
    localparam int HOLD = 512;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic         ovl_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ovl_detector #(.SAMPLE_W(W), .HOLD_SAMPLES(HOLD)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .ovl_flag  (ovl_flag)
    );

    // {expected flag, left, right}
    localparam int NV = 11;
    localparam logic [2*W:0] VEC [NV] = '{
        {1'b0, 24'h000000, 24'h000000},
        {1'b0, 24'h700000, 24'h000000},
        {1'b1, 24'h700001, 24'h000000},
        {1'b1, 24'h000000, 24'h700001},
        {1'b0, 24'h900000, 24'h000000},
        {1'b1, 24'h8FFFFF, 24'h000000},
        {1'b1, 24'h800000, 24'h000000},
        {1'b1, 24'h7FFFFF, 24'h000000},
        {1'b1, 24'h000000, 24'h800000},
        {1'b0, 24'h6FFFFF, 24'h900000},
        {1'b0, 24'h000000, 24'h700000}
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ovl_flag=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic strobe(input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0;
        smp_left  = '0;
        smp_right = '0;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) strobe('0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ovl_flag, 1'b0, "R7 reset state");

        // R1 R2 R3 threshold table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            strobe(VEC[v][2*W-1:W], VEC[v][W-1:0]);
            check(ovl_flag, VEC[v][2*W], $sformatf("R1/R2/R3 vector %0d", v));
        end

        // R8: large samples with the strobe low
        do_reset();
        @(negedge clk);
        smp_left  = 24'h800000;
        smp_right = 24'h7FFFFF;
        repeat (4) @(negedge clk);
        check(ovl_flag, 1'b0, "R8 samples without strobe");
        smp_left  = '0;
        smp_right = '0;

        // R6: hold length after a single trip
        do_reset();
        strobe(24'h7FFFFF, '0);
        quiet(HOLD - 1);
        check(ovl_flag, 1'b1, "R6 high after HOLD-1 quiet strobes");
        quiet(1);
        check(ovl_flag, 1'b0, "R6 low after HOLD quiet strobes");

        // R5: long gaps without strobes do not age the hold
        do_reset();
        strobe('0, 24'h800000);
        repeat (2000) @(negedge clk);
        check(ovl_flag, 1'b1, "R5 held across idle cycles");
        quiet(HOLD - 1);
        check(ovl_flag, 1'b1, "R5 still high after HOLD-1 strobes");
        quiet(1);
        check(ovl_flag, 1'b0, "R5 cleared on HOLD-th strobe");

        // R4: retrigger mid-hold
        do_reset();
        strobe(24'h700001, '0);
        quiet(300);
        check(ovl_flag, 1'b1, "R4 high mid-hold");
        strobe('0, 24'h8FFFFF);
        quiet(HOLD - 1);
        check(ovl_flag, 1'b1, "R4 hold reloaded");
        quiet(1);
        check(ovl_flag, 1'b0, "R4 cleared after reloaded hold");

        // R7: reset mid-hold clears state
        do_reset();
        strobe(24'h800000, '0);
        quiet(10);
        check(ovl_flag, 1'b1, "R7 high before reset");
        do_reset();
        check(ovl_flag, 1'b0, "R7 cleared by reset");
        quiet(2);
        check(ovl_flag, 1'b0, "R7 stays low after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule